// File: doc/BRIEF.md
# Button-Stepped Hex Digit Counter

This block lets a user dial in one 4-bit hexadecimal digit with a single push button: every press adds one to the digit. It runs entirely on a slow sampling clock of roughly 50 Hz. The sampling period is longer than a typical contact-bounce burst, so sampling the button at that rate is the only debouncing the block does. A bounce cannot be seen as two separate presses.

The raw button level is shifted into a two-stage sample register on every sampling edge. When the newest sample shows the button down and the older one shows it up, a press is recognised and the digit steps once on the following edge. The count wraps from 15 back to 0. A long hold produces a single step, and letting go produces none.

The digit is a plain level output with no handshake. It is meant to feed a display multiplexer, which reads it whenever it likes. Generating the slow clock and driving the display are left to the surrounding logic.

Top module: `btn_hex_counter`

## Requirements
- R1: While `rst_n` is low, `digit_o` is 0 and both sample stages hold 0 (button released). A button already held down when reset ends is therefore counted as one fresh press.
- R2: The button is active high (1 = pressed). If the button level sampled at edge k is 1 and the level sampled at edge k-1 was 0, `digit_o` shows the old value plus one after edge k+1.
- R3: The count is modulo 16: a press seen while `digit_o` is 15 makes it 0.
- R4: A button held at 1 for any number of consecutive sampling edges produces exactly one increment.
- R5: A 1-to-0 transition of the sampled button level never changes `digit_o`.
- R6: A button that is high for a single sampling edge still counts as one full press.
- R7: A button level that alternates on every sampling edge produces one increment per two edges, and each increment is exactly +1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| smp_clk | input | 1 | Slow sampling clock (about 50 Hz), rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| btn_i | input | 1 | Raw push-button level, 1 = pressed |
| digit_o | output | DIGIT_W | Current digit value |

## Verification
The hardest case is the one where the recognised press and the state around it interact. Examples are a press that is one sample long, a press that starts right after another ends, a press that crosses the wrap from 15 to 0, and a button that is already down when reset ends. The bench walks every 8-sample button pattern back to back without resetting in between. This puts each pattern boundary in every combination of prior and next levels. It also runs a long train of presses through two wraps, and it releases reset while the button is held.

// File: rtl/bhc_pkg.sv
package bhc_pkg;
  // Number of button sample stages; press detection compares the two newest.
  localparam int SAMPLE_STAGES = 2;

  // Modulo step of a digit of arbitrary width.
  function automatic logic [7:0] bhc_step8(input logic [7:0] v, input int width);
    logic [7:0] mask;
    mask = 8'((1 << width) - 1);
    return (v + 8'd1) & mask;
  endfunction
endpackage

// File: rtl/bhc_sampler.sv
module bhc_sampler #(
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lvl_i,
  output logic [STAGES-1:0] taps_o
);
  logic [STAGES-1:0] stage_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= 1'b0;
        else        stage_q[s] <= lvl_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= 1'b0;
        else        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign taps_o = stage_q;
endmodule

// File: rtl/bhc_press_detect.sv
module bhc_press_detect (
  input  logic newest_i,
  input  logic older_i,
  output logic press_o
);
  // A press is a released-then-pressed pair of consecutive samples.
  always_comb press_o = newest_i & ~older_i;
endmodule

// File: rtl/bhc_counter.sv
module bhc_counter #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step_i,
  output logic [W-1:0] count_o
);
  logic [W-1:0] count_q;
  logic [W-1:0] count_d;

  always_comb begin
    count_d = count_q;
    if (step_i) count_d = W'(bhc_pkg::bhc_step8(8'(count_q), W));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count_q <= '0;
    else        count_q <= count_d;
  end

  assign count_o = count_q;
endmodule

// File: rtl/btn_hex_counter.sv
module btn_hex_counter #(
  parameter int DIGIT_W = 4
) (
  input  logic               smp_clk,
  input  logic               rst_n,
  input  logic               btn_i,
  output logic [DIGIT_W-1:0] digit_o
);
  localparam int NSTG = bhc_pkg::SAMPLE_STAGES;

  logic [NSTG-1:0] samp_q;
  logic            press;

  bhc_sampler #(.STAGES(NSTG)) sampler_i (
    .clk    (smp_clk),
    .rst_n  (rst_n),
    .lvl_i  (btn_i),
    .taps_o (samp_q)
  );

  bhc_press_detect detect_i (
    .newest_i (samp_q[0]),
    .older_i  (samp_q[1]),
    .press_o  (press)
  );

  bhc_counter #(.W(DIGIT_W)) counter_i (
    .clk     (smp_clk),
    .rst_n   (rst_n),
    .step_i  (press),
    .count_o (digit_o)
  );
endmodule

// File: rtl/btn_hex_counter_chk.sv
module btn_hex_counter_chk #(
  parameter int W = 4
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         btn_i,
  input logic [1:0]   samp_i,
  input logic [W-1:0] digit_i
);
  // R1: reset state of count and sample stages
  assert_reset_clear_R1: assert property (@(posedge clk_i)
    !rst_ni |-> (digit_i == '0 && samp_i == 2'b00));

  // R2: newest sample stage tracks the button one edge late
  assert_sample_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> samp_i[0] == $past(btn_i));

  // R2: a detected rising sample pair advances the digit by one
  assert_press_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    samp_i == 2'b01 |=> digit_i == W'($past(digit_i) + 1'b1));

  // R3: wrap from all-ones to zero
  assert_wrap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (samp_i == 2'b01 && digit_i == {W{1'b1}}) |=> digit_i == '0);

  // R4: holding produces no further steps
  assert_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    samp_i == 2'b11 |=> $stable(digit_i));

  // R5: release produces no step
  assert_release_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    samp_i == 2'b10 |=> $stable(digit_i));

  // R7: any change of the digit is a single +1 step
  assert_unit_step_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) && (digit_i != $past(digit_i)) |-> digit_i == W'($past(digit_i) + 1'b1));
endmodule

bind btn_hex_counter btn_hex_counter_chk #(.W(DIGIT_W)) chk_i (
  .clk_i   (smp_clk),
  .rst_ni  (rst_n),
  .btn_i   (btn_i),
  .samp_i  (samp_q),
  .digit_i (digit_o)
);

// File: tb/btn_hex_counter_tb_top.sv
module btn_hex_counter_tb_top;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         btn = 1'b0;
  logic [W-1:0] digit;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  // Reference state derived from the requirements
  int exp_cnt = 0;
  bit prev_lvl = 0;
  bit pending = 0;

  always #10ns clk = ~clk;

  btn_hex_counter #(.DIGIT_W(W)) dut_i (
    .smp_clk (smp_clk_w),
    .rst_n   (rst_n),
    .btn_i   (btn),
    .digit_o (digit)
  );
  wire smp_clk_w = clk;

  task automatic check(input string req, input int expv);
    n_cmp++;
    if (int'(digit) != expv) begin
      n_bad++;
      $display("FAIL %s: digit=%0d expected=%0d at %0t", req, digit, expv, $time);
    end
  endtask

  // Apply one button sample: drive at negedge, clock one edge, land on next negedge.
  task automatic step(input bit b, input string req);
    btn = b;
    @(posedge clk);
    @(negedge clk);
    if (pending) exp_cnt = (exp_cnt + 1) % 16;
    pending  = b && !prev_lvl;
    prev_lvl = b;
    check(req, exp_cnt);
  endtask

  task automatic do_reset(input bit hold_btn);
    @(negedge clk);
    btn   = hold_btn;
    rst_n = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check("R1", 0);
    rst_n = 1'b1;
    exp_cnt = 0; prev_lvl = 0; pending = 0;
  endtask

  initial begin
    #4ms;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int base;
    do_reset(1'b0);
    check("R1", 0);

    // R1: button already held when reset ends counts once
    do_reset(1'b1);
    step(1, "R1");
    step(1, "R1");
    check("R1", 1);
    step(0, "R1");

    // R4: long hold gives one step only
    base = exp_cnt;
    for (int i = 0; i < 30; i++) step(1, "R4");
    check("R4", (base + 1) % 16);
    // R5: release and stay released, no change
    for (int i = 0; i < 10; i++) step(0, "R5");
    check("R5", (base + 1) % 16);

    // R6: single-sample pulses
    base = exp_cnt;
    for (int i = 0; i < 5; i++) begin
      step(1, "R6");
      step(0, "R6");
      step(0, "R6");
    end
    check("R6", (base + 5) % 16);

    // R7: alternate on every edge
    base = exp_cnt;
    for (int i = 0; i < 24; i++) step(i % 2 == 0, "R7");
    step(0, "R7");
    check("R7", (base + 12) % 16);

    // R3: run through two wraps
    for (int i = 0; i < 36; i++) begin
      step(1, "R3");
      step(0, "R3");
    end
    step(0, "R3");

    // R2: exhaustive sweep of every 8-sample pattern, back to back
    for (int p = 0; p < 256; p++) begin
      for (int b = 7; b >= 0; b--) step(p[b], "R2");
    end

    // R1: mid-run reset clears a nonzero count
    step(1, "R2"); step(0, "R2"); step(0, "R2");
    do_reset(1'b0);
    step(0, "R1");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule